// File: doc/BRIEF.md
# DDR DRAM Command Decoder and Bank-State Checker

This block sits beside a four-bank double-data-rate DRAM command bus. On every rising clock edge it takes the sampled chip-select, row strobe, column strobe, write enable, clock enable, bank address and address pins. It turns them into one command code and reports that code one cycle later. It keeps a small timed state machine for each bank. Every command is checked against the state of the bank it targets, or against the state of all banks for the commands that act on the whole device.

A command that breaks the rules raises a registered one-cycle flag, together with the number of the bank at fault. Such a command changes nothing. A legal mode-register write produces a strobe with the register select and the op-code. Precharge, activate, refresh and mode-register recovery times, and the burst length, are parameters counted in clock cycles.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: While `cs_n` is high and `cke` is high, the command is deselect, whatever the other pins show. Command codes appear on `cmd_o` one cycle after the edge that sampled them. The codes are: 0 deselect, 1 NOP, 2 activate, 3 read, 4 read with auto-precharge, 5 write, 6 write with auto-precharge, 7 precharge one bank, 8 precharge all, 9 auto-refresh, 10 mode-register set, 11 burst terminate, 12 clock suspended.
- R2: With `cs_n` low, the levels {ras_n,cas_n,we_n} decode as follows:
  - 111 is NOP.
  - 011 is activate.
  - 101 is read.
  - 100 is write.
  - 010 is precharge.
  - 001 is auto-refresh.
  - 000 is mode-register set.
  - 110 is burst terminate.

  `addr[10]` high turns read and write into their auto-precharge forms, and turns precharge into precharge-all.
- R3: A low `cke` at an edge reports code 12. It ignores the command and raises no flag. No bank state or bank timer advances at that edge.
- R4: After reset every bank is idle, `cmd_o` is 0, and `illegal_o` and `mrs_wr_o` are low. `mrs_op_o` and `mrs_ext_o` read 0 until the first legal mode-register set.
- R5: Bank i is reported on `bank_state_o[4i+3:4i]`. The state codes are: 0 idle, 1 activating, 2 row active, 3 reading, 4 reading with auto-precharge, 5 writing, 6 writing with auto-precharge, 7 precharging, 8 refreshing, 9 mode-register wait. An activate at edge k puts the bank in state 1, and a command at edge k+T_RCD sees it row active.
- R6: A read or write to a bank in state 2, 3 or 5 starts a burst of BURST_LEN/2 cycles.
  - A plain burst returns to state 2 when it ends.
  - An auto-precharge burst then passes through state 7 for T_RP cycles before it returns to idle.
  - A new read or write to a bank that is reading or writing restarts the burst.
- R7: A precharge to a bank in state 2, 3 or 5 enters state 7 for T_RP cycles and then goes idle. This ends any burst in progress. A precharge to an idle or precharging bank is legal and changes nothing. Precharge-all applies the same rules to every bank.
- R8: A legal auto-refresh puts every bank in state 8 for T_RC cycles. A legal mode-register set puts every bank in state 9 for T_MRD cycles. Both commands are illegal if any bank is not idle.
- R9: A legal mode-register set with bank address 0 selects the base register (`mrs_ext_o`=0). Bank address 1 selects the extended register (`mrs_ext_o`=1). The strobe is a one-cycle pulse on `mrs_wr_o`, and `addr` is copied to `mrs_op_o`. Bank addresses 2 and 3 are reserved: the command is illegal, the flag reports that bank address, and no strobe is produced.
- R10: Burst terminate is legal only for a bank in state 3, which it returns to state 2. It is illegal in every other state, including auto-precharge reads and all writes.
- R11: The following commands are illegal:
  - activate to a non-idle bank;
  - read or write to a bank outside states 2, 3 and 5;
  - precharge to a bank in state 1, 4, 6, 8 or 9;
  - precharge-all while any bank is in one of those states.
- R12: `illegal_o` is registered and high for exactly one cycle for each offending command. `illegal_bank_o` names the bank at fault:
  - for single-bank commands, the bank address;
  - for refresh, mode set and precharge-all, the lowest-numbered bank that blocks the command.

  An illegal command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable sampled with the command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address pins; bit 10 is the precharge option |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_state_o | output | 16 | Four 4-bit bank states (R5) |
| mrs_wr_o | output | 1 | Mode-register write strobe |
| mrs_ext_o | output | 1 | 0 base register, 1 extended register |
| mrs_op_o | output | 13 | Mode-register op-code |
| illegal_o | output | 1 | One-cycle illegal-command flag |
| illegal_bank_o | output | 2 | Bank at fault for the flagged command |

## Verification
The hardest situation to reach from the pins is the end of an auto-precharge burst. There the bank falls from a burst state into precharging on its own, with no command on the bus. A command at that exact edge has to be judged against the old state.

Reaching it takes an activate, a wait of T_RCD cycles and then an auto-precharge read or write. The stimulus therefore mixes directed sequences that step through these waits with a long random run. That run is weighted toward activates, reads and writes, so that banks are often open and bursts often overlap with new commands.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_ACT    = 4'd2,
    CMD_READ   = 4'd3,
    CMD_READA  = 4'd4,
    CMD_WRITE  = 4'd5,
    CMD_WRITEA = 4'd6,
    CMD_PRE    = 4'd7,
    CMD_PREA   = 4'd8,
    CMD_REF    = 4'd9,
    CMD_MRS    = 4'd10,
    CMD_TERM   = 4'd11,
    CMD_SUSP   = 4'd12
  } cmd_e;

  typedef enum logic [3:0] {
    BS_IDLE     = 4'd0,
    BS_OPENING  = 4'd1,
    BS_OPEN     = 4'd2,
    BS_RD       = 4'd3,
    BS_RDA      = 4'd4,
    BS_WR       = 4'd5,
    BS_WRA      = 4'd6,
    BS_CLOSING  = 4'd7,
    BS_REFRESH  = 4'd8,
    BS_MODEWAIT = 4'd9
  } bank_st_e;

endpackage

// File: rtl/ddrmon_decode.sv
module ddrmon_decode
  import ddrmon_pkg::*;
(
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic ap_i,
  output cmd_e cmd_o
);

  always_comb begin
    if (!cke_i) begin
      cmd_o = CMD_SUSP;
    end else if (cs_n_i) begin
      cmd_o = CMD_DESEL;
    end else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = ap_i ? CMD_READA  : CMD_READ;
        3'b100:  cmd_o = ap_i ? CMD_WRITEA : CMD_WRITE;
        3'b010:  cmd_o = ap_i ? CMD_PREA   : CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_TERM;
      endcase
    end
  end

endmodule

// File: rtl/ddrmon_legal.sv
module ddrmon_legal
  import ddrmon_pkg::*;
#(
  parameter int BA_W = 2,
  localparam int NB  = 1 << BA_W
) (
  input  cmd_e            cmd_i,
  input  logic [BA_W-1:0] ba_i,
  input  bank_st_e        st_i [NB],
  output logic            bad_o,
  output logic [BA_W-1:0] bad_bank_o
);

  bank_st_e        tgt;
  logic            any_busy, any_block;
  logic [BA_W-1:0] first_busy, first_block;

  function automatic logic blocks_pre(input bank_st_e s);
    return (s == BS_OPENING) || (s == BS_RDA) || (s == BS_WRA) ||
           (s == BS_REFRESH) || (s == BS_MODEWAIT);
  endfunction

  always_comb begin
    any_busy    = 1'b0;
    any_block   = 1'b0;
    first_busy  = '0;
    first_block = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (st_i[i] != BS_IDLE) begin
        any_busy   = 1'b1;
        first_busy = BA_W'(i);
      end
      if (blocks_pre(st_i[i])) begin
        any_block   = 1'b1;
        first_block = BA_W'(i);
      end
    end
  end

  assign tgt = st_i[ba_i];

  always_comb begin
    bad_o      = 1'b0;
    bad_bank_o = ba_i;
    unique case (cmd_i)
      CMD_ACT: bad_o = (tgt != BS_IDLE);
      CMD_READ, CMD_READA, CMD_WRITE, CMD_WRITEA:
        bad_o = !((tgt == BS_OPEN) || (tgt == BS_RD) || (tgt == BS_WR));
      CMD_PRE: bad_o = blocks_pre(tgt);
      CMD_PREA: begin
        bad_o      = any_block;
        bad_bank_o = first_block;
      end
      CMD_REF: begin
        bad_o      = any_busy;
        bad_bank_o = first_busy;
      end
      CMD_MRS: begin
        if (any_busy) begin
          bad_o      = 1'b1;
          bad_bank_o = first_busy;
        end else begin
          bad_o = (ba_i > BA_W'(1));
        end
      end
      CMD_TERM: bad_o = (tgt != BS_RD);
      default:  bad_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ddrmon_bank.sv
module ddrmon_bank
  import ddrmon_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RC    = 10,
  parameter int T_MRD   = 2,
  parameter int T_BURST = 4,
  localparam int TMAX_A = (T_RCD > T_RP) ? T_RCD : T_RP,
  localparam int TMAX_B = (T_RC > T_MRD) ? T_RC : T_MRD,
  localparam int TMAX_C = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B,
  localparam int TMAX   = (TMAX_C > T_BURST) ? TMAX_C : T_BURST,
  localparam int CW     = $clog2(TMAX) + 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  logic     go_i,
  input  cmd_e     cmd_i,
  input  logic     hit_i,
  output bank_st_e st_o
);

  localparam logic [CW-1:0] L_RCD   = CW'(T_RCD - 2);
  localparam logic [CW-1:0] L_RP    = CW'(T_RP - 2);
  localparam logic [CW-1:0] L_RC    = CW'(T_RC - 2);
  localparam logic [CW-1:0] L_MRD   = CW'(T_MRD - 2);
  localparam logic [CW-1:0] L_BURST = CW'(T_BURST - 2);

  bank_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_dec;
  logic          take, dn;

  assign take    = go_i && hit_i;
  assign dn      = (cnt_q == '0);
  assign cnt_dec = cnt_q - 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      BS_IDLE: begin
        if (take) begin
          if (cmd_i == CMD_ACT) begin
            st_d = BS_OPENING; cnt_d = L_RCD;
          end else if (cmd_i == CMD_REF) begin
            st_d = BS_REFRESH; cnt_d = L_RC;
          end else if (cmd_i == CMD_MRS) begin
            st_d = BS_MODEWAIT; cnt_d = L_MRD;
          end
        end
      end
      BS_OPENING: begin
        if (dn) st_d = BS_OPEN;
        else    cnt_d = cnt_dec;
      end
      BS_CLOSING, BS_REFRESH, BS_MODEWAIT: begin
        if (dn) st_d = BS_IDLE;
        else    cnt_d = cnt_dec;
      end
      BS_RDA, BS_WRA: begin
        if (dn) begin
          st_d = BS_CLOSING; cnt_d = L_RP;
        end else begin
          cnt_d = cnt_dec;
        end
      end
      default: begin
        if (st_q != BS_OPEN) begin
          if (dn) st_d = BS_OPEN;
          else    cnt_d = cnt_dec;
        end
        if (take) begin
          case (cmd_i)
            CMD_READ:   begin st_d = BS_RD;  cnt_d = L_BURST; end
            CMD_READA:  begin st_d = BS_RDA; cnt_d = L_BURST; end
            CMD_WRITE:  begin st_d = BS_WR;  cnt_d = L_BURST; end
            CMD_WRITEA: begin st_d = BS_WRA; cnt_d = L_BURST; end
            CMD_PRE, CMD_PREA: begin st_d = BS_CLOSING; cnt_d = L_RP; end
            CMD_TERM:   st_d = BS_OPEN;
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BS_IDLE;
      cnt_q <= '0;
    end else if (en_i) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o = st_q;

  // R5: an activating bank only ever opens
  a_r5_opening_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_OPENING) |=> (st_q inside {BS_OPENING, BS_OPEN}));

  // R7: a precharging bank only ever goes idle
  a_r7_closing_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_CLOSING) |=> (st_q inside {BS_CLOSING, BS_IDLE}));

  // R6: an auto-precharge read ends only in precharging
  a_r6_rda_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_RDA) |=> (st_q inside {BS_RDA, BS_CLOSING}));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddrmon_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 8,
  localparam int NB       = 1 << BA_W,
  localparam int AP_BIT   = 10,
  localparam int T_BURST  = BURST_LEN / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  addr,
  output logic [3:0]        cmd_o,
  output logic [NB*4-1:0]   bank_state_o,
  output logic              mrs_wr_o,
  output logic              mrs_ext_o,
  output logic [ROW_W-1:0]  mrs_op_o,
  output logic              illegal_o,
  output logic [BA_W-1:0]   illegal_bank_o
);

  cmd_e            cmd_dec;
  bank_st_e        bank_st [NB];
  logic [NB-1:0]   hit;
  logic            bad, go, mrs_go;
  logic [BA_W-1:0] bad_bank;

  cmd_e            cmd_q;
  logic            ill_q, mrs_wr_q, mrs_ext_q;
  logic [BA_W-1:0] ill_bank_q;
  logic [ROW_W-1:0] mrs_op_q;

  ddrmon_decode u_decode (
    .cke_i   (cke),
    .cs_n_i  (cs_n),
    .ras_n_i (ras_n),
    .cas_n_i (cas_n),
    .we_n_i  (we_n),
    .ap_i    (addr[AP_BIT]),
    .cmd_o   (cmd_dec)
  );

  ddrmon_legal #(.BA_W(BA_W)) u_legal (
    .cmd_i      (cmd_dec),
    .ba_i       (ba),
    .st_i       (bank_st),
    .bad_o      (bad),
    .bad_bank_o (bad_bank)
  );

  assign go     = (cmd_dec != CMD_SUSP) && !bad;
  assign mrs_go = go && (cmd_dec == CMD_MRS);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      hit[i] = (ba == BA_W'(i)) ||
               (cmd_dec == CMD_PREA) || (cmd_dec == CMD_REF) || (cmd_dec == CMD_MRS);
    end
  end

  for (genvar gi = 0; gi < NB; gi++) begin : g_bank
    ddrmon_bank #(
      .T_RCD   (T_RCD),
      .T_RP    (T_RP),
      .T_RC    (T_RC),
      .T_MRD   (T_MRD),
      .T_BURST (T_BURST)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (cke),
      .go_i   (go),
      .cmd_i  (cmd_dec),
      .hit_i  (hit[gi]),
      .st_o   (bank_st[gi])
    );
    assign bank_state_o[gi*4 +: 4] = bank_st[gi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= CMD_DESEL;
      ill_q      <= 1'b0;
      ill_bank_q <= '0;
      mrs_wr_q   <= 1'b0;
    end else begin
      cmd_q      <= cmd_dec;
      ill_q      <= bad;
      ill_bank_q <= bad_bank;
      mrs_wr_q   <= mrs_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs_ext_q <= 1'b0;
      mrs_op_q  <= '0;
    end else if (mrs_go) begin
      mrs_ext_q <= ba[0];
      mrs_op_q  <= addr;
    end
  end

  assign cmd_o          = cmd_q;
  assign illegal_o      = ill_q;
  assign illegal_bank_o = ill_bank_q;
  assign mrs_wr_o       = mrs_wr_q;
  assign mrs_ext_o      = mrs_ext_q;
  assign mrs_op_o       = mrs_op_q;

  logic all_modewait;
  always_comb begin
    all_modewait = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (bank_st[i] != BS_MODEWAIT) all_modewait = 1'b0;
    end
  end

  // R3: a suspended edge freezes every bank
  a_r3_suspend_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bank_state_o));

  // R8: a mode-register write leaves every bank in recovery
  a_r8_mrs_all_wait: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_wr_o |-> all_modewait);

  // R12: only real commands can be flagged
  a_r12_flag_real_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !(cmd_o inside {CMD_DESEL, CMD_NOP, CMD_SUSP}));

  // R9: no strobe for a flagged command
  a_r9_no_strobe_when_bad: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !mrs_wr_o);

endmodule

// File: tb/ddr_cmd_monitor_tb_top.sv
module ddr_cmd_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 3;
  localparam int T_RP  = 3;
  localparam int T_RC  = 10;
  localparam int T_MRD = 2;
  localparam int BL    = 8;
  localparam int BC    = BL / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  cmd_o;
  logic [15:0] bank_state_o;
  logic        mrs_wr_o, mrs_ext_o, illegal_o;
  logic [12:0] mrs_op_o;
  logic [1:0]  illegal_bank_o;

  int n_checks = 0;
  int n_fail   = 0;

  int m_st  [4];
  int m_tgo [4];
  int n_edge;
  logic        m_ext;
  logic [12:0] m_op;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr_cmd_monitor #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .BURST_LEN(BL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .bank_state_o(bank_state_o), .mrs_wr_o(mrs_wr_o), .mrs_ext_o(mrs_ext_o),
    .mrs_op_o(mrs_op_o), .illegal_o(illegal_o), .illegal_bank_o(illegal_bank_o)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic open_like(input int s);
    return (s == 2) || (s == 3) || (s == 5);
  endfunction

  function automatic logic pre_blocker(input int s);
    return (s == 1) || (s == 4) || (s == 6) || (s == 8) || (s == 9);
  endfunction

  function automatic logic [15:0] pack_model();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) v[i*4 +: 4] = 4'(m_st[i]);
    return v;
  endfunction

  // one command at one edge: drive, predict, compare
  task automatic apply(input logic k, input logic c, input logic r, input logic ca,
                       input logic w, input logic [1:0] b, input logic [12:0] ad);
    int ec, eb, tgt;
    logic bad, ewr;
    string tg;
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = ad;
    if (!k) ec = 12;
    else if (c) ec = 0;
    else begin
      case ({r, ca, w})
        3'b111: ec = 1;
        3'b011: ec = 2;
        3'b101: ec = ad[10] ? 4 : 3;
        3'b100: ec = ad[10] ? 6 : 5;
        3'b010: ec = ad[10] ? 8 : 7;
        3'b001: ec = 9;
        3'b000: ec = 10;
        default: ec = 11;
      endcase
    end
    tgt = m_st[b];
    bad = 1'b0;
    eb  = b;
    case (ec)
      2: bad = (tgt != 0);
      3, 4, 5, 6: bad = !open_like(tgt);
      7: bad = pre_blocker(tgt);
      8: for (int i = 3; i >= 0; i--) if (pre_blocker(m_st[i])) begin bad = 1; eb = i; end
      9: for (int i = 3; i >= 0; i--) if (m_st[i] != 0) begin bad = 1; eb = i; end
      10: begin
        for (int i = 3; i >= 0; i--) if (m_st[i] != 0) begin bad = 1; eb = i; end
        if (!bad && b > 1) bad = 1;
      end
      11: bad = (tgt != 3);
      default: bad = 0;
    endcase
    ewr = (ec == 10) && !bad;
    if (ewr) begin m_ext = b[0]; m_op = ad; end
    if (k) begin
      for (int i = 0; i < 4; i++) begin
        logic hit, chg;
        hit = (b == 2'(i)) || ec == 8 || ec == 9 || ec == 10;
        chg = 0;
        if (!bad && hit) begin
          case (ec)
            2: begin m_st[i] = 1; m_tgo[i] = n_edge + T_RCD - 1; chg = 1; end
            3, 4, 5, 6: begin m_st[i] = ec; m_tgo[i] = n_edge + BC - 1; chg = 1; end
            7, 8: if (open_like(m_st[i])) begin
              m_st[i] = 7; m_tgo[i] = n_edge + T_RP - 1; chg = 1;
            end
            9:  begin m_st[i] = 8; m_tgo[i] = n_edge + T_RC - 1;  chg = 1; end
            10: begin m_st[i] = 9; m_tgo[i] = n_edge + T_MRD - 1; chg = 1; end
            11: begin m_st[i] = 2; chg = 1; end
            default: ;
          endcase
        end
        if (!chg && m_st[i] != 0 && m_st[i] != 2 && m_tgo[i] == n_edge) begin
          case (m_st[i])
            1, 3, 5: m_st[i] = 2;
            4, 6: begin m_st[i] = 7; m_tgo[i] = n_edge + T_RP - 1; end
            default: m_st[i] = 0;
          endcase
        end
      end
      n_edge++;
    end
    @(posedge clk);
    @(negedge clk);
    tg = !k ? "R3" : (c ? "R1" : "R2");
    check(cmd_o == 4'(ec), tg, cmd_o, ec);
    case (ec)
      2: tg = "R5"; 3, 4, 5, 6: tg = "R6"; 7, 8: tg = "R7";
      9, 10: tg = "R8"; 11: tg = "R10"; 12: tg = "R3"; default: tg = "R5";
    endcase
    check(bank_state_o == pack_model(), tg, bank_state_o, pack_model());
    check(illegal_o == bad, bad ? "R11" : "R12", illegal_o, bad);
    if (bad) check(illegal_bank_o == 2'(eb), "R12", illegal_bank_o, eb);
    check({mrs_wr_o, mrs_ext_o, mrs_op_o} == {ewr, m_ext, m_op}, "R9",
          {mrs_wr_o, mrs_ext_o, mrs_op_o}, {ewr, m_ext, m_op});
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) apply(1, 0, 1, 1, 1, 2'd0, 13'd0);
  endtask

  task automatic issue(input int code, input logic [1:0] b, input logic [12:0] ad);
    case (code)
      1:  apply(1, 0, 1, 1, 1, b, ad);
      2:  apply(1, 0, 0, 1, 1, b, ad);
      3:  apply(1, 0, 1, 0, 1, b, ad & ~13'h400);
      4:  apply(1, 0, 1, 0, 1, b, ad | 13'h400);
      5:  apply(1, 0, 1, 0, 0, b, ad & ~13'h400);
      6:  apply(1, 0, 1, 0, 0, b, ad | 13'h400);
      7:  apply(1, 0, 0, 1, 0, b, ad & ~13'h400);
      8:  apply(1, 0, 0, 1, 0, b, ad | 13'h400);
      9:  apply(1, 0, 0, 0, 1, b, ad);
      10: apply(1, 0, 0, 0, 0, b, ad);
      default: apply(1, 0, 1, 1, 0, b, ad);
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0D0D));
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tgo[i] = 0; end
    n_edge = 0; m_ext = 0; m_op = '0;
    rst_n = 0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
    repeat (3) @(negedge clk);
    // R4: reset state
    check(bank_state_o == 16'h0 && cmd_o == 4'd0 && !illegal_o && !mrs_wr_o
          && mrs_op_o == 13'd0 && !mrs_ext_o, "R4", {cmd_o, bank_state_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: deselect with noise on the other pins
    apply(1, 1, 0, 0, 0, 2'd3, 13'h1FFF);
    // R9: base, extended and reserved mode writes
    issue(10, 2'd0, 13'h0123);
    issue(10, 2'd0, 13'h0042);       // R8: during recovery -> illegal
    nop(2);
    issue(10, 2'd1, 13'h0777);
    nop(2);
    issue(10, 2'd2, 13'h0555);       // reserved
    // R5: activate, too-early read, then read on time
    issue(2, 2'd0, 13'h0010);
    issue(3, 2'd0, 13'h0);           // R11: read while activating
    nop(T_RCD - 2);
    issue(3, 2'd0, 13'h0);
    issue(11, 2'd0, 13'h0);          // R10: terminate plain read
    // R10: terminate on auto-precharge read and on write are illegal
    issue(2, 2'd1, 13'h0);
    nop(T_RCD);
    issue(4, 2'd1, 13'h0);
    issue(11, 2'd1, 13'h0);
    issue(3, 2'd1, 13'h0);           // R11: same-bank read during auto-precharge
    issue(7, 2'd1, 13'h0);           // precharge during auto-precharge burst
    issue(5, 2'd0, 13'h0);
    issue(11, 2'd0, 13'h0);
    // R8: refresh with an open bank
    issue(9, 2'd0, 13'h0);
    issue(2, 2'd0, 13'h0);           // activate to open bank
    nop(BC + T_RP);
    // R7: precharge all, precharge to idle bank, then refresh
    issue(8, 2'd0, 13'h0);
    issue(7, 2'd2, 13'h0);
    nop(T_RP);
    issue(9, 2'd3, 13'h0);
    issue(2, 2'd2, 13'h0);           // R11: activate during refresh
    nop(T_RC);
    // R3: clock suspended while activating
    issue(2, 2'd3, 13'h0);
    apply(0, 0, 1, 0, 1, 2'd3, 13'h0);
    apply(0, 0, 0, 1, 0, 2'd3, 13'h400);
    nop(T_RCD);
    issue(6, 2'd3, 13'h0);
    nop(BC + T_RP + 1);

    // random run, biased to keep banks busy
    for (int it = 0; it < 4000; it++) begin
      int p, code;
      logic [1:0] b;
      logic [12:0] ad;
      p  = $urandom % 100;
      b  = 2'($urandom);
      ad = 13'($urandom);
      if (p < 4) apply(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), b, ad);
      else if (p < 8) apply(1, 1, 1'($urandom), 1'($urandom), 1'($urandom), b, ad);
      else if (p < 35) code = 1;
      else if (p < 55) code = 2;
      else if (p < 68) code = 3 + ($urandom % 2);
      else if (p < 81) code = 5 + ($urandom % 2);
      else if (p < 90) code = 7 + ($urandom % 2);
      else if (p < 94) code = 11;
      else if (p < 97) code = 9;
      else code = 10;
      if (p >= 8) issue(code, b, ad);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule